// File: doc/BRIEF.md
# Resistive Touch Measurement Sequencer

This block paces an automatic resistive touch panel scan. A slow timing tick, one clock wide and derived from a low-frequency timing clock, advances a fixed chain of phases for each coordinate pair. The chain is: a settle delay with the X plate driven, an X conversion, a settle delay with the Y plate driven, a Y conversion, a pen-detect phase, a touch-detect phase and an update wait. The chain then starts over. All delays are programmable and counted in ticks. Conversions are handed to an external converter through a start strobe and a done pulse.

Each completed pair is passed downstream together with the pen level sampled at the end of touch-detect. Pairs are grouped into measurements of four, and the last pair of each group is flagged. A control word gates the sequence, selects the per-axis resolution that goes to the converter, and enables a group interrupt.

States: `ST_IDLE`, `ST_SETTLE_X`, `ST_CONV_X`, `ST_SETTLE_Y`, `ST_CONV_Y`, `ST_PEN_DET`, `ST_TOUCH_DET`, `ST_UPDATE_WAIT`.

Transitions:
- `ST_IDLE` goes to `ST_SETTLE_X` when run is set.
- A timed phase (`ST_SETTLE_X`, `ST_SETTLE_Y`, `ST_PEN_DET`, `ST_TOUCH_DET`, `ST_UPDATE_WAIT`) leaves when its tick count expires.
- A conversion phase (`ST_CONV_X`, `ST_CONV_Y`) leaves on an accepted done.
- Each exit goes to the next state in the chain when run is set, and to `ST_IDLE` otherwise. The chain wraps from `ST_UPDATE_WAIT` back to `ST_SETTLE_X`.
- Run is control bit 0 AND control bit 2.

Top module: `touch_meas_seq`

## Requirements
- R1: Plate drives follow the order `drive_x` (settle X and X conversion), then `drive_y` (settle Y and Y conversion), then `pen_drive` (pen-detect only). At most one of the three is high at a time, and each handoff happens in a single cycle.
- R2: Each settle phase consumes exactly `dly_settle` ticks.
- R3: Pen-detect consumes `dly_pen` ticks, touch-detect consumes `dly_touch` ticks and update-wait consumes `dly_update` ticks. The delay ports are unsigned and `DELAY_W` bits wide, so the full-scale value is 255 at the default width.
- R4: A delay value of 0 behaves as a one-tick phase.
- R5: On entering a conversion phase, `adc_start` is high for exactly one cycle. The phase, and its plate drive, holds until the first `adc_done` after that strobe. A done pulse outside a conversion phase has no effect on timing or on the data.
- R6: When touch-detect ends, `pair_valid` pulses for one cycle. With it come the X and Y samples of that pair and `pair_pen`, which is the `pen_sense` level at the last touch-detect cycle.
- R7: `pair_last` is 1 with every fourth pair counted from the start of a run. The count restarts whenever the sequence passes through idle.
- R8: `group_irq` pulses together with a `pair_valid` that carries `pair_last`, and only when control bit 11 is 1.
- R9: After reset every output is 0. The sequence leaves idle only while control bit 0 (auto-enable) and control bit 2 (power-up) are both 1.
- R10: Clearing either run bit lets the current phase finish and then returns to idle. No `pair_valid` is produced for a pair whose touch-detect phase has not completed.
- R11: While an axis is driven, `adc_bits` equals 10 minus the resolution field for that axis. The X field is control bits 9:7 and the Y field is control bits 6:4, so a field value of 0 means 10-bit samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timing tick |
| ctrl_word | input | 12 | Control: bit0 auto-enable, bit2 power-up, bits 9:7 X resolution code, bits 6:4 Y resolution code, bit11 group interrupt enable |
| dly_settle | input | DELAY_W | Settle delay in ticks, used for both axes |
| dly_pen | input | DELAY_W | Pen-detect delay in ticks |
| dly_touch | input | DELAY_W | Touch-detect delay in ticks |
| dly_update | input | DELAY_W | Update-wait delay in ticks |
| adc_start | output | 1 | Conversion request strobe |
| adc_bits | output | 4 | Requested conversion width for the driven axis |
| adc_done | input | 1 | Conversion complete pulse |
| adc_data | input | ADC_W | Conversion result, valid with adc_done |
| drive_x | output | 1 | X plate drive |
| drive_y | output | 1 | Y plate drive |
| pen_drive | output | 1 | Pen-detect bias drive |
| pen_sense | input | 1 | Pen contact level, 1 means touched |
| pair_valid | output | 1 | Pair output strobe |
| pair_x | output | ADC_W | X sample of the pair |
| pair_y | output | ADC_W | Y sample of the pair |
| pair_pen | output | 1 | Pen level of the pair |
| pair_last | output | 1 | Pair closes a four-pair measurement |
| group_irq | output | 1 | Group interrupt pulse |

## Verification
The bench builds the block with its defaults: an 8-bit delay width, 10-bit samples and four pairs per measurement, with a tick every fourth clock. With 8-bit delays, a full-scale 255-tick update wait can be measured tick by tick in about a thousand cycles. The zero-delay and reference settings are measured on the same per-phase tick counters. Since a group is only four pairs long, two group boundaries, the interrupt gating and the restart after a mid-group stop all fall within a few thousand cycles.

// File: rtl/tms_pkg.sv
package tms_pkg;

    localparam int CTRL_W        = 12;
    localparam int CTL_AUTO      = 0;
    localparam int CTL_POWER     = 2;
    localparam int RES_Y_LSB     = 4;
    localparam int RES_X_LSB     = 7;
    localparam int RES_W         = 3;
    localparam int CTL_GROUP_IRQ = 11;
    localparam int FULL_RES      = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE_X,
        ST_CONV_X,
        ST_SETTLE_Y,
        ST_CONV_Y,
        ST_PEN_DET,
        ST_TOUCH_DET,
        ST_UPDATE_WAIT
    } tms_state_e;

    // Resolution code counts bits removed from full width.
    function automatic logic [3:0] res_to_bits(input logic [RES_W-1:0] code);
        return 4'(FULL_RES) - {1'b0, code};
    endfunction

endpackage

// File: rtl/tms_phase_timer.sv
module tms_phase_timer #(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               load,
    input  logic [DELAY_W-1:0] load_val,
    output logic               expire
);

    logic [DELAY_W-1:0] remain;

    // A zero length is stretched to one tick so no phase can stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= (load_val == '0) ? DELAY_W'(1) : load_val;
        end else if (tick && (remain > DELAY_W'(1))) begin
            remain <= remain - DELAY_W'(1);
        end
    end

    assign expire = tick && (remain == DELAY_W'(1));

endmodule

// File: rtl/tms_pair_builder.sv
module tms_pair_builder #(
    parameter int ADC_W = 10,
    parameter int PAIRS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_x,
    input  logic             cap_y,
    input  logic [ADC_W-1:0] sample,
    input  logic             emit,
    input  logic             pen_level,
    input  logic             restart,
    input  logic             irq_en,
    output logic             pair_valid,
    output logic [ADC_W-1:0] pair_x,
    output logic [ADC_W-1:0] pair_y,
    output logic             pair_pen,
    output logic             pair_last,
    output logic             group_irq
);

    localparam int IDX_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAIRS - 1);

    logic [ADC_W-1:0] x_hold;
    logic [ADC_W-1:0] y_hold;
    logic [IDX_W-1:0] pair_idx;
    logic             closes_group;

    assign closes_group = (pair_idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_hold     <= '0;
            y_hold     <= '0;
            pair_idx   <= '0;
            pair_valid <= 1'b0;
            pair_x     <= '0;
            pair_y     <= '0;
            pair_pen   <= 1'b0;
            pair_last  <= 1'b0;
            group_irq  <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            group_irq  <= 1'b0;
            if (cap_x) x_hold <= sample;
            if (cap_y) y_hold <= sample;
            if (restart) begin
                pair_idx <= '0;
            end else if (emit) begin
                pair_valid <= 1'b1;
                pair_x     <= x_hold;
                pair_y     <= y_hold;
                pair_pen   <= pen_level;
                pair_last  <= closes_group;
                group_irq  <= closes_group && irq_en;
                pair_idx   <= closes_group ? '0 : pair_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/touch_meas_seq.sv
module touch_meas_seq
    import tms_pkg::*;
#(
    parameter int DELAY_W = 8,
    parameter int ADC_W   = 10,
    parameter int PAIRS   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [CTRL_W-1:0]  ctrl_word,
    input  logic [DELAY_W-1:0] dly_settle,
    input  logic [DELAY_W-1:0] dly_pen,
    input  logic [DELAY_W-1:0] dly_touch,
    input  logic [DELAY_W-1:0] dly_update,
    output logic               adc_start,
    output logic [3:0]         adc_bits,
    input  logic               adc_done,
    input  logic [ADC_W-1:0]   adc_data,
    output logic               drive_x,
    output logic               drive_y,
    output logic               pen_drive,
    input  logic               pen_sense,
    output logic               pair_valid,
    output logic [ADC_W-1:0]   pair_x,
    output logic [ADC_W-1:0]   pair_y,
    output logic               pair_pen,
    output logic               pair_last,
    output logic               group_irq
);

    tms_state_e         state;
    tms_state_e         state_nxt;
    logic               run;
    logic               expire;
    logic               conv_issued;
    logic               done_ok;
    logic               phase_load;
    logic [DELAY_W-1:0] phase_len;
    logic               in_conv;
    logic               unused_ctrl_bits;

    assign run              = ctrl_word[CTL_AUTO] && ctrl_word[CTL_POWER];
    assign unused_ctrl_bits = ^{ctrl_word[1], ctrl_word[3], ctrl_word[10]};
    assign done_ok          = adc_done && conv_issued;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:        if (run)     state_nxt = ST_SETTLE_X;
            ST_SETTLE_X:    if (expire)  state_nxt = run ? ST_CONV_X      : ST_IDLE;
            ST_CONV_X:      if (done_ok) state_nxt = run ? ST_SETTLE_Y    : ST_IDLE;
            ST_SETTLE_Y:    if (expire)  state_nxt = run ? ST_CONV_Y      : ST_IDLE;
            ST_CONV_Y:      if (done_ok) state_nxt = run ? ST_PEN_DET     : ST_IDLE;
            ST_PEN_DET:     if (expire)  state_nxt = run ? ST_TOUCH_DET   : ST_IDLE;
            ST_TOUCH_DET:   if (expire)  state_nxt = run ? ST_UPDATE_WAIT : ST_IDLE;
            ST_UPDATE_WAIT: if (expire)  state_nxt = run ? ST_SETTLE_X    : ST_IDLE;
            default:                     state_nxt = ST_IDLE;
        endcase
    end

    // Phase length chosen for the state being entered
    always_comb begin
        unique case (state_nxt)
            ST_SETTLE_X, ST_SETTLE_Y: phase_len = dly_settle;
            ST_PEN_DET:               phase_len = dly_pen;
            ST_TOUCH_DET:             phase_len = dly_touch;
            ST_UPDATE_WAIT:           phase_len = dly_update;
            default:                  phase_len = '0;
        endcase
    end

    assign phase_load = (state_nxt != state);

    // Conversion request bookkeeping: one strobe per conversion phase
    always_ff @(posedge clk) begin
        if (!rst_n)          conv_issued <= 1'b0;
        else if (phase_load) conv_issued <= 1'b0;
        else if (adc_start)  conv_issued <= 1'b1;
    end

    // Outputs decoded from state
    always_comb begin
        drive_x   = 1'b0;
        drive_y   = 1'b0;
        pen_drive = 1'b0;
        in_conv   = 1'b0;
        adc_bits  = 4'd0;
        unique case (state)
            ST_SETTLE_X: begin
                drive_x  = 1'b1;
                adc_bits = res_to_bits(ctrl_word[RES_X_LSB +: RES_W]);
            end
            ST_CONV_X: begin
                drive_x  = 1'b1;
                in_conv  = 1'b1;
                adc_bits = res_to_bits(ctrl_word[RES_X_LSB +: RES_W]);
            end
            ST_SETTLE_Y: begin
                drive_y  = 1'b1;
                adc_bits = res_to_bits(ctrl_word[RES_Y_LSB +: RES_W]);
            end
            ST_CONV_Y: begin
                drive_y  = 1'b1;
                in_conv  = 1'b1;
                adc_bits = res_to_bits(ctrl_word[RES_Y_LSB +: RES_W]);
            end
            ST_PEN_DET: pen_drive = 1'b1;
            default: ;
        endcase
        adc_start = in_conv && !conv_issued;
    end

    tms_phase_timer #(
        .DELAY_W (DELAY_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (phase_load),
        .load_val (phase_len),
        .expire   (expire)
    );

    tms_pair_builder #(
        .ADC_W (ADC_W),
        .PAIRS (PAIRS)
    ) u_pairs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_x      ((state == ST_CONV_X) && done_ok),
        .cap_y      ((state == ST_CONV_Y) && done_ok),
        .sample     (adc_data),
        .emit       ((state == ST_TOUCH_DET) && expire),
        .pen_level  (pen_sense),
        .restart    (state == ST_IDLE),
        .irq_en     (ctrl_word[CTL_GROUP_IRQ]),
        .pair_valid (pair_valid),
        .pair_x     (pair_x),
        .pair_y     (pair_y),
        .pair_pen   (pair_pen),
        .pair_last  (pair_last),
        .group_irq  (group_irq)
    );

endmodule

// File: rtl/touch_meas_seq_checks.sv
module touch_meas_seq_checks (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] ctrl_word,
    input logic        adc_start,
    input logic        drive_x,
    input logic        drive_y,
    input logic        pen_drive,
    input logic        pair_valid,
    input logic        pair_last,
    input logic        group_irq
);

    assert_one_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drive_x, drive_y, pen_drive}));

    assert_y_follows_x_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_y) |-> $fell(drive_x));

    assert_pen_follows_y_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pen_drive) |-> $fell(drive_y));

    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    assert_start_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> $past(ctrl_word[0] && ctrl_word[2]));

    assert_pair_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    assert_irq_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        group_irq |-> (pair_valid && pair_last));

endmodule

bind touch_meas_seq touch_meas_seq_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_word  (ctrl_word),
    .adc_start  (adc_start),
    .drive_x    (drive_x),
    .drive_y    (drive_y),
    .pen_drive  (pen_drive),
    .pair_valid (pair_valid),
    .pair_last  (pair_last),
    .group_irq  (group_irq)
);

// File: tb/touch_meas_seq_test.sv
`timescale 1ns/1ps
module touch_meas_seq_test;

    localparam int DW  = 8;
    localparam int AW  = 10;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [11:0]   ctrl_word = '0;
    logic [DW-1:0] dly_settle = '0, dly_pen = '0, dly_touch = '0, dly_update = '0;
    logic          adc_start;
    logic [3:0]    adc_bits;
    logic          adc_done;
    logic [AW-1:0] adc_data;
    logic          drive_x, drive_y, pen_drive;
    logic          pen_sense = 1'b0;
    logic          pair_valid, pair_pen, pair_last, group_irq;
    logic [AW-1:0] pair_x, pair_y;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    touch_meas_seq uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_word(ctrl_word),
        .dly_settle(dly_settle), .dly_pen(dly_pen), .dly_touch(dly_touch),
        .dly_update(dly_update), .adc_start(adc_start), .adc_bits(adc_bits),
        .adc_done(adc_done), .adc_data(adc_data), .drive_x(drive_x),
        .drive_y(drive_y), .pen_drive(pen_drive), .pen_sense(pen_sense),
        .pair_valid(pair_valid), .pair_x(pair_x), .pair_y(pair_y),
        .pair_pen(pair_pen), .pair_last(pair_last), .group_irq(group_irq)
    );

    // Tick every fourth clock
    logic [1:0] div;
    always @(posedge clk) begin
        if (!rst_n) begin
            div  <= '0;
            tick <= 1'b0;
        end else begin
            div  <= div + 2'd1;
            tick <= (div == 2'd3);
        end
    end

    // Converter model: fixed latency, distinct X and Y codes
    logic          model_done = 1'b0;
    logic [AW-1:0] model_data = '0;
    logic          stray_done = 1'b0;
    logic [AW-1:0] stray_data = '0;
    int            lat = 0;
    logic          conv_y = 1'b0;
    logic [AW-1:0] seq_n = '0;

    assign adc_done = model_done | stray_done;
    assign adc_data = stray_done ? stray_data : model_data;

    always @(posedge clk) begin
        model_done <= 1'b0;
        if (adc_start) begin
            lat    <= LAT;
            conv_y <= drive_y;
        end else if (lat != 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
                model_done <= 1'b1;
                model_data <= conv_y ? (10'h080 + seq_n) : (10'h200 + seq_n);
                seq_n      <= seq_n + 10'd3;
            end
        end
    end

    // Monitor: per-phase tick counts and a pair log
    int sx_cnt, sy_cnt, m_sx, m_sy, pd_cnt, m_pd, t_cnt, m_t, u_cnt, m_u;
    bit xconv, yconv, in_t, in_u, prev_pen;
    int pc, starts, irq_cnt;
    logic [3:0]    bits_x, bits_y;
    logic [AW-1:0] cur_x, cur_y;
    logic [AW-1:0] lx[16], ly[16], ex[16], ey[16];
    logic          lp[16], ll[16];

    always @(negedge clk) begin
        if (!rst_n) begin
            sx_cnt = 0; sy_cnt = 0; m_sx = 0; m_sy = 0; pd_cnt = 0; m_pd = 0;
            t_cnt = 0; m_t = 0; u_cnt = 0; m_u = 0; xconv = 0; yconv = 0;
            in_t = 0; in_u = 0; prev_pen = 0; pc = 0; starts = 0; irq_cnt = 0;
            bits_x = '0; bits_y = '0; cur_x = '0; cur_y = '0;
        end else begin
            if (drive_x) begin
                if (adc_start) begin
                    xconv = 1; m_sx = sx_cnt; bits_x = adc_bits; starts++;
                end else if (!xconv) sx_cnt += int'(tick);
                else if (adc_done) cur_x = adc_data;
            end else begin
                sx_cnt = 0; xconv = 0;
            end
            if (drive_y) begin
                if (adc_start) begin
                    yconv = 1; m_sy = sy_cnt; bits_y = adc_bits; starts++;
                end else if (!yconv) sy_cnt += int'(tick);
                else if (adc_done) cur_y = adc_data;
            end else begin
                sy_cnt = 0; yconv = 0;
            end
            if (pen_drive) pd_cnt += int'(tick);
            if (!pen_drive && prev_pen) begin
                m_pd = pd_cnt; pd_cnt = 0; in_t = 1; in_u = 0; t_cnt = int'(tick);
            end else if (pair_valid) begin
                lx[pc % 16] = pair_x; ly[pc % 16] = pair_y;
                lp[pc % 16] = pair_pen; ll[pc % 16] = pair_last;
                ex[pc % 16] = cur_x; ey[pc % 16] = cur_y;
                if (group_irq) irq_cnt++;
                pc++;
                m_t = t_cnt; in_t = 0; in_u = 1; u_cnt = int'(tick);
            end else if (in_t) begin
                t_cnt += int'(tick);
            end else if (in_u) begin
                if (drive_x) begin
                    m_u = u_cnt; in_u = 0;
                end else u_cnt += int'(tick);
            end
            prev_pen = pen_drive;
        end
    end

    task automatic nxt();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int eff(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    task automatic set_delays(input int s, input int p, input int t, input int u);
        dly_settle = DW'(s); dly_pen = DW'(p); dly_touch = DW'(t); dly_update = DW'(u);
    endtask

    task automatic wait_pairs(input int n);
        int tgt = pc + n;
        while (pc < tgt) nxt();
    endtask

    task automatic go_idle();
        ctrl_word = '0;
        repeat (1300) nxt();
    endtask

    // R9: reset state and run gating
    task automatic test_reset_and_gate();
        int s0;
        nxt();
        chk({drive_x, drive_y, pen_drive, adc_start, pair_valid, group_irq} == 6'b0,
            "R9", "outputs in reset", 1, 0);
        rst_n = 1'b1;
        repeat (20) nxt();
        chk({drive_x, drive_y, pen_drive, adc_start, pair_valid, adc_bits} == '0,
            "R9", "outputs idle after reset", 1, 0);
        set_delays(2, 4, 16, 8);
        s0 = starts;
        ctrl_word = 12'h001;
        repeat (200) nxt();
        chk(starts == s0 && !drive_x, "R9", "auto-enable alone starts nothing", starts - s0, 0);
        ctrl_word = 12'h004;
        repeat (200) nxt();
        chk(starts == s0 && !drive_x, "R9", "power-up alone starts nothing", starts - s0, 0);
        go_idle();
    endtask

    // R2 R3 R4: tick counts per phase
    task automatic test_timing(input int s, input int p, input int t, input int u,
                               input string tag);
        set_delays(s, p, t, u);
        ctrl_word = 12'h005;
        wait_pairs(2);
        chk(m_sx == eff(s), tag, "settle X ticks (R2)", m_sx, eff(s));
        chk(m_sy == eff(s), tag, "settle Y ticks (R2)", m_sy, eff(s));
        chk(m_pd == eff(p), tag, "pen-detect ticks (R3)", m_pd, eff(p));
        chk(m_t  == eff(t), tag, "touch-detect ticks (R3)", m_t, eff(t));
        chk(m_u  == eff(u), tag, "update-wait ticks (R3)", m_u, eff(u));
        go_idle();
    endtask

    // R11: resolution codes
    task automatic test_resolution();
        set_delays(1, 1, 1, 1);
        ctrl_word = 12'h005 | (12'd2 << 7) | (12'd5 << 4);
        wait_pairs(1);
        chk(bits_x == 4'd8, "R11", "X width for code 2", bits_x, 8);
        chk(bits_y == 4'd5, "R11", "Y width for code 5", bits_y, 5);
        go_idle();
        ctrl_word = 12'h005;
        wait_pairs(1);
        chk(bits_x == 4'd10 && bits_y == 4'd10, "R11", "code 0 gives 10 bits",
            bits_x, 10);
        go_idle();
    endtask

    // R6 R7 R8: pair contents, grouping and interrupt
    task automatic test_pairs();
        int base, i0;
        set_delays(2, 4, 16, 8);
        pen_sense = 1'b1;
        base = pc; i0 = irq_cnt;
        ctrl_word = 12'h805;
        wait_pairs(8);
        for (int k = 0; k < 8; k++) begin
            int ix = (base + k) % 16;
            chk(lx[ix] == ex[ix], "R6", "pair X sample", lx[ix], ex[ix]);
            chk(ly[ix] == ey[ix], "R6", "pair Y sample", ly[ix], ey[ix]);
            chk(lp[ix] == 1'b1, "R6", "pair pen level", lp[ix], 1);
            chk(ll[ix] == (k % 4 == 3), "R7", "last flag position", ll[ix], k % 4 == 3);
        end
        chk(irq_cnt - i0 == 2, "R8", "group interrupts with bit11 set", irq_cnt - i0, 2);
        go_idle();
        pen_sense = 1'b0;
        base = pc; i0 = irq_cnt;
        ctrl_word = 12'h005;
        wait_pairs(4);
        chk(ll[(base + 3) % 16] == 1'b1, "R7", "fourth pair closes group", ll[(base + 3) % 16], 1);
        chk(lp[base % 16] == 1'b0, "R6", "pen level low", lp[base % 16], 0);
        chk(irq_cnt == i0, "R8", "no interrupt with bit11 clear", irq_cnt - i0, 0);
        go_idle();
    endtask

    // R10 R7: stop behaviour and restart of the group count
    task automatic test_stop();
        int s0, p0, base;
        bit x_seen = 0;
        set_delays(4, 2, 2, 20);
        ctrl_word = 12'h005;
        while (!drive_y) nxt();
        ctrl_word = 12'h000;
        s0 = starts; p0 = pc;
        nxt();
        chk(drive_y == 1'b1, "R10", "settle Y continues after stop", drive_y, 1);
        repeat (300) nxt();
        chk(starts == s0, "R10", "no Y conversion after stop", starts - s0, 0);
        chk(pc == p0, "R10", "no partial pair emitted", pc - p0, 0);
        chk(!drive_x && !drive_y, "R10", "idle after stop", drive_x | drive_y, 0);
        ctrl_word = 12'h005;
        wait_pairs(2);
        ctrl_word = 12'h001;
        repeat (300) begin
            nxt();
            if (drive_x) x_seen = 1;
        end
        chk(!x_seen, "R10", "power-up clear ends after update wait", x_seen, 0);
        base = pc;
        ctrl_word = 12'h005;
        wait_pairs(4);
        chk(ll[(base + 1) % 16] == 1'b0 && ll[(base + 3) % 16] == 1'b1, "R7",
            "group count restarts after idle", ll[(base + 3) % 16], 1);
        go_idle();
    endtask

    // R5: strobe, hold until done, stray done ignored
    task automatic test_handshake();
        int s0, hold, base;
        set_delays(8, 1, 1, 1);
        base = pc;
        ctrl_word = 12'h005;
        while (!drive_x) nxt();
        s0 = starts;
        repeat (3) nxt();
        stray_data = 10'h3AA;
        stray_done = 1'b1;
        nxt();
        stray_done = 1'b0;
        nxt();
        chk(drive_x && !adc_start && starts == s0, "R5", "stray done does not end settle",
            starts - s0, 0);
        while (!adc_start) nxt();
        nxt();
        chk(!adc_start, "R5", "start strobe one cycle", adc_start, 0);
        hold = 1;
        while (drive_x) begin
            nxt();
            hold++;
        end
        chk(hold == LAT + 2, "R5", "X phase holds until done", hold, LAT + 2);
        wait_pairs(1);
        chk(lx[base % 16] == ex[base % 16] && lx[base % 16] != 10'h3AA, "R5",
            "stray data not captured", lx[base % 16], ex[base % 16]);
        go_idle();
    endtask

    initial begin
        test_reset_and_gate();
        test_timing(2, 4, 16, 88, "R3");
        test_timing(0, 0, 0, 0, "R4");
        test_timing(5, 3, 1, 255, "R2");
        test_resolution();
        test_pairs();
        test_stop();
        test_handshake();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule